// File: doc/BRIEF.md
# Exception-Aware Multicycle Control Unit

This block is the hard-wired sequencer for a multicycle processor datapath. In every cycle it drives the datapath controls, such as memory strobes, register and instruction-register load enables, ALU operand and operation selects, and the PC source and load. It steps through fetch, decode and one short execution path for each supported instruction class. It also recognises two exception sources. The first is an opcode that matches no supported class, found during decode. The second is a signed overflow reported by the ALU while a register-register operation executes.

When either exception occurs, the unit spends one cycle on it. In that cycle it has the ALU form PC − 4, so that the saved address names the faulting instruction and not the one after it. It strobes that result into the exception-PC register. It writes a cause word that carries the exception code in bits 5:2, steers the PC to a fixed handler vector, and clears its interrupt-enable status bit. Fetch follows in the next cycle. The ALU, the register file and the memories belong to the surrounding datapath.

Top module: `mc_exc_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the unit is in fetch. Fetch asserts pc_load, ir_write and mem_read with i_or_d=0, pc_source=00, alu_src_a=0, alu_src_b=01 (constant four) and alu_op=00 (add). epc_write and cause_write stay low in this state.
- R2: The cycle after fetch is decode. Decode asserts ab_write and no PC, memory or register write. It classifies the opcode as follows: 0x23 load, 0x2B store, 0x00 register-register, 0x02 jump, 0x04 branch-if-equal, 0x0D OR-immediate.
- R3: Any other opcode makes the cycle after decode an undefined-instruction exception cycle. In it: epc_write=1, cause_write=1 with code 10 in cause_value[5:2], pc_load=1 with pc_source=11, and the ALU set to PC − 4 (alu_src_a=0, alu_src_b=01, alu_op=01).
- R4: If alu_overflow is high during register-register execute (alu_op=10), the next cycle is an overflow exception cycle with code 12 and the same outputs as R3. reg_write stays low for that instruction.
- R5: alu_overflow has no effect in any other cycle. Instructions of other classes complete exactly as they would with it low.
- R6: handler_pc carries the handler vector 0x8000_0080. pc_source=11 appears only together with epc_write, cause_write and status_write.
- R7: cause_value is all zeros except bits 5:2 during a cause write. epc_write and cause_write occur only in exception cycles.
- R8: status_ie is 1 after reset. status_write pulses in every exception cycle, and status_ie reads 0 from the following cycle on.
- R9: The cycle after any exception cycle is fetch.
- R10: The branch cycle selects alu_src_a=1, alu_src_b=00, alu_op=01 and pc_source=01, and pc_load equals alu_equal.
- R11: Load runs address (alu_src_a=1, alu_src_b=10, alu_op=00), then a read with mem_read and i_or_d=1, then write-back with reg_write, mem_to_reg=1 and reg_dst=0. Store runs the same address cycle, then mem_write with i_or_d=1.
- R12: OR-immediate executes with alu_src_a=1, alu_src_b=10, alu_op=11 and imm_zero_ext=1, then writes back with reg_write, reg_dst=0 and mem_to_reg=0. Jump asserts pc_load with pc_source=10.
- R13: Register-register execute selects alu_src_a=1, alu_src_b=00, alu_op=10 and imm_zero_ext=0. Without overflow, the next cycle writes back with reg_write, reg_dst=1 and mem_to_reg=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPC_W | Opcode field of the instruction register |
| alu_equal | input | 1 | ALU reports equal operands |
| alu_overflow | input | 1 | ALU reports signed overflow |
| pc_load | output | 1 | PC load enable, with the branch condition folded in |
| pc_source | output | 2 | PC input select: ALU, branch target, jump, handler vector |
| i_or_d | output | 1 | Memory address select: 0 = PC, 1 = ALU output |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| ab_write | output | 1 | Operand registers load |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Destination select: 1 = rd, 0 = rt |
| mem_to_reg | output | 1 | Write-back source: 1 = memory data |
| alu_src_a | output | 1 | ALU A select: 0 = PC, 1 = operand A |
| alu_src_b | output | 2 | ALU B select: B, four, immediate, immediate << 2 |
| alu_op | output | 2 | ALU operation: add, subtract, function field, OR |
| imm_zero_ext | output | 1 | Immediate is zero-extended instead of sign-extended |
| epc_write | output | 1 | Exception PC register load from the ALU |
| cause_write | output | 1 | Cause register load |
| cause_value | output | XLEN | Value for the cause register |
| status_write | output | 1 | Status register update strobe |
| status_ie | output | 1 | Exception/interrupt enable status bit |
| handler_pc | output | XLEN | Handler vector fed to the PC select |

## Verification
Two functions can fall in the same cycle: an overflow flag arriving during register-register execute, and the write-back that would normally follow. The exception must win, and the destination write must never happen. The bench holds alu_overflow high through entire instructions of every opcode, with the equal flag both low and high. Every register-register pass must then trade its write-back for the code-12 exception cycle. Every other class must run its normal sequence, with no exception output and no status change.

// File: rtl/mc_ctrl_pkg.sv
`timescale 1ns/1ps
package mc_ctrl_pkg;

  // opcode encodings recognised in decode
  localparam logic [5:0] OPC_LOAD   = 6'h23;
  localparam logic [5:0] OPC_STORE  = 6'h2B;
  localparam logic [5:0] OPC_REG    = 6'h00;
  localparam logic [5:0] OPC_JUMP   = 6'h02;
  localparam logic [5:0] OPC_BRANCH = 6'h04;
  localparam logic [5:0] OPC_ORIMM  = 6'h0D;

  // exception codes, placed in the cause field
  localparam int          XC_W     = 4;
  localparam logic [XC_W-1:0] XC_UNDEF = 4'd10;
  localparam logic [XC_W-1:0] XC_OVF   = 4'd12;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;
  localparam logic [1:0] ALU_OR    = 2'b11;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_BROFF = 2'b11;

  localparam logic [1:0] PCS_ALU    = 2'b00;
  localparam logic [1:0] PCS_TARGET = 2'b01;
  localparam logic [1:0] PCS_JUMP   = 2'b10;
  localparam logic [1:0] PCS_VECTOR = 2'b11;

  localparam logic [31:0] VECTOR_DEFAULT = 32'h8000_0080;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MADDR, ST_MRD, ST_LDWB, ST_STWR,
    ST_REX, ST_RWB, ST_BR, ST_JMP, ST_IEX, ST_IWB, ST_XUND, ST_XOVF
  } ctl_state_e;

  typedef enum logic [2:0] {
    OC_LOAD, OC_STORE, OC_REG, OC_JUMP, OC_BRANCH, OC_ORIMM, OC_ILLEGAL
  } op_class_e;

  typedef struct packed {
    logic            pc_wr;
    logic            pc_wr_cond;
    logic [1:0]      pc_src;
    logic            iord;
    logic            mrd;
    logic            mwr;
    logic            irw;
    logic            abw;
    logic            rw;
    logic            rdst;
    logic            m2r;
    logic            srca;
    logic [1:0]      srcb;
    logic [1:0]      aluop;
    logic            zx;
    logic            epcw;
    logic            causew;
    logic            statw;
    logic [XC_W-1:0] xcode;
  } ctl_word_t;

endpackage

// File: rtl/mc_rst_sync.sv
`timescale 1ns/1ps
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  // asserts at once, releases after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mc_opc_class.sv
`timescale 1ns/1ps
module mc_opc_class
  import mc_ctrl_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output op_class_e        cls
);
  always_comb begin
    if      (opcode == OPC_W'(OPC_LOAD))   cls = OC_LOAD;
    else if (opcode == OPC_W'(OPC_STORE))  cls = OC_STORE;
    else if (opcode == OPC_W'(OPC_REG))    cls = OC_REG;
    else if (opcode == OPC_W'(OPC_JUMP))   cls = OC_JUMP;
    else if (opcode == OPC_W'(OPC_BRANCH)) cls = OC_BRANCH;
    else if (opcode == OPC_W'(OPC_ORIMM))  cls = OC_ORIMM;
    else                                   cls = OC_ILLEGAL;
  end
endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  ctl_state_e state,
  input  op_class_e  cls,
  input  logic       alu_overflow,
  output ctl_state_e nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          OC_LOAD, OC_STORE: nxt = ST_MADDR;
          OC_REG:            nxt = ST_REX;
          OC_JUMP:           nxt = ST_JMP;
          OC_BRANCH:         nxt = ST_BR;
          OC_ORIMM:          nxt = ST_IEX;
          default:           nxt = ST_XUND;
        endcase
      end
      ST_MADDR:  nxt = (cls == OC_LOAD) ? ST_MRD : ST_STWR;
      ST_MRD:    nxt = ST_LDWB;
      // overflow is looked at here and nowhere else
      ST_REX:    nxt = alu_overflow ? ST_XOVF : ST_RWB;
      ST_IEX:    nxt = ST_IWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_out.sv
`timescale 1ns/1ps
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  ctl_state_e state,
  output ctl_word_t  ctl
);
  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.mrd   = 1'b1;
        ctl.irw   = 1'b1;
        ctl.pc_wr = 1'b1;
        ctl.srcb  = SRCB_FOUR;
        ctl.aluop = ALU_ADD;
        ctl.pc_src = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.abw   = 1'b1;
        ctl.srcb  = SRCB_BROFF;
        ctl.aluop = ALU_ADD;
      end
      ST_MADDR: begin
        ctl.srca  = 1'b1;
        ctl.srcb  = SRCB_IMM;
        ctl.aluop = ALU_ADD;
      end
      ST_MRD: begin
        ctl.mrd  = 1'b1;
        ctl.iord = 1'b1;
      end
      ST_LDWB: begin
        ctl.rw  = 1'b1;
        ctl.m2r = 1'b1;
      end
      ST_STWR: begin
        ctl.mwr  = 1'b1;
        ctl.iord = 1'b1;
      end
      ST_REX: begin
        ctl.srca  = 1'b1;
        ctl.srcb  = SRCB_REG;
        ctl.aluop = ALU_FUNCT;
      end
      ST_RWB: begin
        ctl.rw   = 1'b1;
        ctl.rdst = 1'b1;
      end
      ST_BR: begin
        ctl.srca       = 1'b1;
        ctl.srcb       = SRCB_REG;
        ctl.aluop      = ALU_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PCS_TARGET;
      end
      ST_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_JUMP;
      end
      ST_IEX: begin
        ctl.srca  = 1'b1;
        ctl.srcb  = SRCB_IMM;
        ctl.aluop = ALU_OR;
        ctl.zx    = 1'b1;
      end
      ST_IWB: begin
        ctl.rw = 1'b1;
      end
      ST_XUND, ST_XOVF: begin
        // ALU forms PC - 4 for the saved address
        ctl.srcb   = SRCB_FOUR;
        ctl.aluop  = ALU_SUB;
        ctl.epcw   = 1'b1;
        ctl.causew = 1'b1;
        ctl.statw  = 1'b1;
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PCS_VECTOR;
        ctl.xcode  = (state == ST_XUND) ? XC_UNDEF : XC_OVF;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_exc_ctrl.sv
`timescale 1ns/1ps
module mc_exc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          OPC_W       = 6,
  parameter int          CAUSE_LSB   = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic        IE_RESET    = 1'b1,
  parameter logic [31:0] HANDLER_PC  = VECTOR_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_equal,
  input  logic             alu_overflow,
  output logic             pc_load,
  output logic [1:0]       pc_source,
  output logic             i_or_d,
  output logic             mem_read,
  output logic             mem_write,
  output logic             ir_write,
  output logic             ab_write,
  output logic             reg_write,
  output logic             reg_dst,
  output logic             mem_to_reg,
  output logic             alu_src_a,
  output logic [1:0]       alu_src_b,
  output logic [1:0]       alu_op,
  output logic             imm_zero_ext,
  output logic             epc_write,
  output logic             cause_write,
  output logic [XLEN-1:0]  cause_value,
  output logic             status_write,
  output logic             status_ie,
  output logic [XLEN-1:0]  handler_pc
);
  logic       srst_n;
  op_class_e  cls;
  ctl_state_e state_q, state_d;
  ctl_word_t  ctl;
  logic       ie_q;
  logic       ie_en;

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  mc_opc_class #(.OPC_W(OPC_W)) u_cls (
    .opcode(opcode), .cls(cls)
  );

  mc_next_state u_nxt (
    .state(state_q), .cls(cls), .alu_overflow(alu_overflow), .nxt(state_d)
  );

  mc_ctrl_out u_out (
    .state(state_q), .ctl(ctl)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  // enable bit: cleared on entry to any exception cycle
  assign ie_en = ctl.statw;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    ie_q <= IE_RESET;
    else if (ie_en) ie_q <= 1'b0;
  end

  assign pc_load      = ctl.pc_wr | (ctl.pc_wr_cond & alu_equal);
  assign pc_source    = ctl.pc_src;
  assign i_or_d       = ctl.iord;
  assign mem_read     = ctl.mrd;
  assign mem_write    = ctl.mwr;
  assign ir_write     = ctl.irw;
  assign ab_write     = ctl.abw;
  assign reg_write    = ctl.rw;
  assign reg_dst      = ctl.rdst;
  assign mem_to_reg   = ctl.m2r;
  assign alu_src_a    = ctl.srca;
  assign alu_src_b    = ctl.srcb;
  assign alu_op       = ctl.aluop;
  assign imm_zero_ext = ctl.zx;
  assign epc_write    = ctl.epcw;
  assign cause_write  = ctl.causew;
  assign cause_value  = ctl.causew ? (XLEN'(ctl.xcode) << CAUSE_LSB) : '0;
  assign status_write = ctl.statw;
  assign status_ie    = ie_q;
  assign handler_pc   = XLEN'(HANDLER_PC);
endmodule

// File: rtl/mc_exc_ctrl_chk.sv
`timescale 1ns/1ps
module mc_exc_ctrl_chk
  import mc_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OPC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             alu_equal,
  input logic             alu_overflow,
  input logic             pc_load,
  input logic [1:0]       pc_source,
  input logic             ir_write,
  input logic             ab_write,
  input logic             reg_write,
  input logic             alu_src_a,
  input logic [1:0]       alu_op,
  input logic             epc_write,
  input logic             cause_write,
  input logic [XLEN-1:0]  cause_value,
  input logic             status_write,
  input logic             status_ie
);
  logic known_opc;
  assign known_opc = (opcode == OPC_W'(OPC_LOAD))  || (opcode == OPC_W'(OPC_STORE)) ||
                     (opcode == OPC_W'(OPC_REG))   || (opcode == OPC_W'(OPC_JUMP))  ||
                     (opcode == OPC_W'(OPC_BRANCH))|| (opcode == OPC_W'(OPC_ORIMM));

  assert_undef_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_write && !known_opc) |=> (epc_write && cause_write && cause_value[5:2] == XC_UNDEF));

  assert_no_overflow_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == ALU_FUNCT && alu_overflow) |=>
      (!reg_write && epc_write && cause_value[5:2] == XC_OVF));

  assert_ovf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_write && cause_value[5:2] == XC_OVF) |-> $past(alu_op == ALU_FUNCT && alu_overflow));

  assert_vector_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_source == PCS_VECTOR) |-> (pc_load && epc_write && cause_write && status_write));

  assert_cause_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_write |-> (cause_value == '0));

  assert_ie_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_write |=> !status_ie);

  assert_ie_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_ie |=> !status_ie);

  assert_exc_to_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    epc_write |=> ir_write);

  assert_branch_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == ALU_SUB && alu_src_a) |-> (pc_load == alu_equal));
endmodule

bind mc_exc_ctrl mc_exc_ctrl_chk #(.XLEN(32), .OPC_W(6)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_equal(alu_equal),
  .alu_overflow(alu_overflow), .pc_load(pc_load), .pc_source(pc_source),
  .ir_write(ir_write), .ab_write(ab_write), .reg_write(reg_write),
  .alu_src_a(alu_src_a), .alu_op(alu_op), .epc_write(epc_write),
  .cause_write(cause_write), .cause_value(cause_value),
  .status_write(status_write), .status_ie(status_ie)
);

// File: tb/sim_mc_exc_ctrl.sv
`timescale 1ns/1ps
module sim_mc_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  opcode;
  logic        alu_equal, alu_overflow;
  logic        pc_load, i_or_d, mem_read, mem_write, ir_write, ab_write;
  logic        reg_write, reg_dst, mem_to_reg, alu_src_a, imm_zero_ext;
  logic [1:0]  pc_source, alu_src_b, alu_op;
  logic        epc_write, cause_write, status_write, status_ie;
  logic [31:0] cause_value, handler_pc;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic exp_ie;
  bit   after_exc;

  always #2.5 clk = ~clk;

  mc_exc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_equal(alu_equal),
    .alu_overflow(alu_overflow), .pc_load(pc_load), .pc_source(pc_source),
    .i_or_d(i_or_d), .mem_read(mem_read), .mem_write(mem_write),
    .ir_write(ir_write), .ab_write(ab_write), .reg_write(reg_write),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a),
    .alu_src_b(alu_src_b), .alu_op(alu_op), .imm_zero_ext(imm_zero_ext),
    .epc_write(epc_write), .cause_write(cause_write), .cause_value(cause_value),
    .status_write(status_write), .status_ie(status_ie), .handler_pc(handler_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mux vector: {pc_source, i_or_d, reg_dst, mem_to_reg, alu_src_a, alu_src_b, alu_op, imm_zero_ext}
  function automatic logic [10:0] mx(input logic [1:0] pcs, input logic iord, input logic rdst,
                                     input logic m2r, input logic sa, input logic [1:0] sb,
                                     input logic [1:0] op, input logic zx);
    return {pcs, iord, rdst, m2r, sa, sb, op, zx};
  endfunction

  // one cycle: drive at the falling edge, sample 1 ns later
  task automatic cyc(input string tag, input logic [5:0] opc, input logic ovf, input logic eq,
                     input logic [8:0] ectl, input logic [10:0] emux, input logic [10:0] care,
                     input logic [3:0] ecode);
    logic [10:0] amux;
    @(negedge clk);
    opcode = opc; alu_overflow = ovf; alu_equal = eq;
    #1;
    amux = mx(pc_source, i_or_d, reg_dst, mem_to_reg, alu_src_a, alu_src_b, alu_op, imm_zero_ext);
    chk(tag, 32'({pc_load, ir_write, mem_read, mem_write, reg_write,
                  epc_write, cause_write, status_write, ab_write}), 32'(ectl));
    chk(tag, 32'(amux & care), 32'(emux & care));
    chk("R7", cause_value, (ecode != 4'd0) ? (32'(ecode) << 2) : 32'd0);
    chk("R8", 32'(status_ie), 32'(exp_ie));
    if (ecode != 4'd0) exp_ie = 1'b0;
  endtask

  localparam logic [10:0] CARE_ALU = mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, 1'b1);
  localparam logic [10:0] CARE_WB  = mx(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0);
  localparam logic [10:0] CARE_MEM = mx(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
  localparam logic [10:0] CARE_PCA = mx(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0);
  localparam logic [10:0] CARE_PC  = mx(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0);
  localparam logic [10:0] CARE_F   = mx(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11, 1'b0);

  task automatic run_instr(input logic [5:0] opc, input logic ovf, input logic eq);
    string t;
    logic  known;
    known = (opc == 6'h23) || (opc == 6'h2B) || (opc == 6'h00) ||
            (opc == 6'h02) || (opc == 6'h04) || (opc == 6'h0D);
    // R5: overflow held high through a non-register instruction must change nothing
    t = (ovf && known && opc != 6'h00) ? "R5" : "";
    cyc(after_exc ? "R9" : "R1", opc, ovf, eq, 9'b111000000,
        mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0), CARE_F, 4'd0);
    after_exc = 1'b0;
    cyc("R2", opc, ovf, eq, 9'b000000001, 11'd0, 11'd0, 4'd0);
    case (opc)
      6'h23: begin
        cyc((t != "") ? t : "R11", opc, ovf, eq, 9'b000000000,
            mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0), CARE_ALU & ~11'd1, 4'd0);
        cyc((t != "") ? t : "R11", opc, ovf, eq, 9'b001000000,
            mx(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0), CARE_MEM, 4'd0);
        cyc((t != "") ? t : "R11", opc, ovf, eq, 9'b000010000,
            mx(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0), CARE_WB, 4'd0);
      end
      6'h2B: begin
        cyc((t != "") ? t : "R11", opc, ovf, eq, 9'b000000000,
            mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00, 1'b0), CARE_ALU & ~11'd1, 4'd0);
        cyc((t != "") ? t : "R11", opc, ovf, eq, 9'b000100000,
            mx(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0), CARE_MEM, 4'd0);
      end
      6'h00: begin
        cyc("R13", opc, ovf, eq, 9'b000000000,
            mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b10, 1'b0), CARE_ALU, 4'd0);
        if (ovf) begin
          cyc("R4", opc, ovf, eq, 9'b100001110,
              mx(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0), CARE_PCA, 4'd12);
          after_exc = 1'b1;
        end else begin
          cyc("R13", opc, ovf, eq, 9'b000010000,
              mx(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0), CARE_WB, 4'd0);
        end
      end
      6'h0D: begin
        cyc((t != "") ? t : "R12", opc, ovf, eq, 9'b000000000,
            mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11, 1'b1), CARE_ALU, 4'd0);
        cyc((t != "") ? t : "R12", opc, ovf, eq, 9'b000010000,
            mx(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0), CARE_WB, 4'd0);
      end
      6'h04: begin
        cyc((t != "") ? t : "R10", opc, ovf, eq, {eq, 8'b0},
            mx(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01, 1'b0), CARE_PCA, 4'd0);
      end
      6'h02: begin
        cyc((t != "") ? t : "R12", opc, ovf, eq, 9'b100000000,
            mx(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0), CARE_PC, 4'd0);
      end
      default: begin
        cyc("R3", opc, ovf, eq, 9'b100001110,
            mx(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0), CARE_PCA, 4'd10);
        after_exc = 1'b1;
      end
    endcase
  endtask

  initial begin
    rst_n = 1'b0; opcode = 6'h00; alu_equal = 1'b0; alu_overflow = 1'b0;
    exp_ie = 1'b1; after_exc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", 32'(status_ie), 32'd1);
    chk("R1", 32'({epc_write, cause_write, status_write}), 32'd0);
    chk("R6", handler_pc, 32'h8000_0080);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    // full opcode sweep, overflow and equal in every combination
    for (int o = 0; o < 64; o++)
      for (int v = 0; v < 2; v++)
        for (int e = 0; e < 2; e++)
          run_instr(6'(o), v[0], e[0]);
    // final fetch after the last instruction
    run_instr(6'h02, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule